// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked request port and an external asynchronous static RAM of 128K bytes. It turns each accepted request into a correctly ordered sequence of address, chip-enable, output-enable and write-enable levels. It also drives the data bus through separate output, output-enable and input signals. Every phase of a memory access is stretched to a whole number of clock cycles. These counts are derived at elaboration from nanosecond parameters and the clock period, always rounded up.

After reset the controller keeps the memory deselected and refuses requests until a long supply settling interval has elapsed. While the request port has nothing to do, the chip enable stays low for a programmable number of cycles and is then released, which parks the memory in low-power standby. Leaving standby costs one full read-cycle time with the memory selected but idle. After a read, the controller lets the memory release the bus before it drives write data.

Top module: `sram_async_ctrl`

## Requirements
- R1: From reset until PU_CYC = ceil(T_PU_NS / CLK_NS) cycles have passed, sram_ce_n, sram_oe_n and sram_we_n are high, sram_dq_oe is low and req_ready is low. req_ready first rises no later than PU_CYC+3 cycles after reset is released.
- R2: A read holds sram_ce_n low, sram_oe_n low and sram_we_n high for at least RD_CYC = ceil(max(T_RC,T_AA,T_DOE) / CLK_NS) cycles. It samples sram_dq_in at the end of that window and returns the byte on rsp_rdata with a one-cycle rsp_valid pulse, exactly one pulse per read.
- R3: A write holds sram_we_n low with sram_ce_n low and sram_oe_n high for PWE_CYC cycles while driving the bus. sram_addr and sram_dq_out stay unchanged throughout the pulse and during the one cycle after sram_we_n rises, and sram_dq_oe stays high in that cycle too. The byte committed on the rising edge of sram_we_n is the requested one at the requested address.
- R4: Before sram_dq_oe rises after a read, sram_oe_n has been high with the bus undriven for at least HZ_CYC = ceil(T_HZ_NS / CLK_NS) cycles.
- R5: Strobe encoding: sram_we_n low never occurs together with sram_oe_n low or with sram_ce_n high.
- R6: After IDLE_CYC cycles in the selected idle state with no request, sram_ce_n goes high and sram_dq_oe is low (standby). IDLE_CYC = 0 keeps the memory selected.
- R7: When sram_ce_n falls, the memory stays selected with sram_oe_n and sram_we_n high for at least WAKE_CYC = max(RD_CYC, HZ_CYC) cycles before the first read or write strobe.
- R8: req_ready is high only while no memory strobe is active. Accepted requests are carried out in order, and no request is lost.
- R9: If a request is presented in the last idle cycle before standby would be entered, the request wins: sram_ce_n stays low and the access starts without a wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also marks supply arrival |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Request accepted at this edge when valid |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read byte |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | DATA_W | Data from the memory |

## Verification
The idle timeout and a newly arriving request can meet in the same cycle: in the last idle cycle before standby, the controller must choose between releasing chip enable and starting the access. The bench waits for a read response, counts idle cycles to place a read request exactly in that last idle cycle, and requires that chip enable never rose. It then repeats the test one cycle later and requires exactly one rise of chip enable followed by a full wake-up interval. A memory model on the strobes judges both runs and also checks encoding, turnaround and hold.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP, ST_STBY, ST_IDLE, ST_WAKE,
      ST_RD, ST_TURN, ST_WR, ST_WHOLD
   } ctrl_st_e;

   // cycles covering ns at clock period clk_ns, never below one
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/sram_ctrl_tmr.sv
module sram_ctrl_tmr #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_pwrup.sv
module sram_ctrl_pwrup #(
   parameter int unsigned HOLD_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int unsigned HW = sram_ctrl_pkg::cnt_bits(HOLD_CYC);
   localparam logic [HW-1:0] LIMIT = HW'(HOLD_CYC);

   logic [HW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q != LIMIT)
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == LIMIT);

   // R1
   hold_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CLK_NS    = 10,
   parameter int unsigned T_RC_NS   = 10,
   parameter int unsigned T_AA_NS   = 10,
   parameter int unsigned T_DOE_NS  = 5,
   parameter int unsigned T_HZ_NS   = 5,
   parameter int unsigned T_PWE_NS  = 7,
   parameter int unsigned T_PU_NS   = 100000,
   parameter int unsigned IDLE_CYC  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);
   localparam int unsigned RD_CYC   = ns2cyc(umax(T_RC_NS, umax(T_AA_NS, T_DOE_NS)), CLK_NS);
   localparam int unsigned HZ_CYC   = ns2cyc(T_HZ_NS, CLK_NS);
   localparam int unsigned PWE_CYC  = ns2cyc(T_PWE_NS, CLK_NS);
   localparam int unsigned WAKE_CYC = umax(RD_CYC, HZ_CYC);
   localparam int unsigned PU_CYC   = ns2cyc(T_PU_NS, CLK_NS);
   localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, HZ_CYC), umax(PWE_CYC, WAKE_CYC));
   localparam int unsigned CW       = cnt_bits(MAX_CYC);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: bus widths must be positive");
      end
      if (CLK_NS == 0) begin : g_bad_clk
         $error("sram_async_ctrl: clock period must be nonzero");
      end
   endgenerate

   ctrl_st_e          st_q, st_d;
   logic              wr_q, last_rd_q, accept, idle_expire;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic              rsp_q, tmr_zero, tmr_load, pu_done;
   logic [CW-1:0]     tmr_val;

   sram_ctrl_pwrup #(.HOLD_CYC(PU_CYC)) u_pwrup (
      .clk(clk), .rst_n(rst_n), .done(pu_done));

   sram_ctrl_tmr #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

   // idle-to-standby timeout, removed entirely when IDLE_CYC is zero
   generate
      if (IDLE_CYC > 0) begin : g_idle
         localparam int unsigned IW = cnt_bits(IDLE_CYC);
         logic [IW-1:0] idle_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idle_q <= '0;
            else if (st_q != ST_IDLE || accept)
               idle_q <= '0;
            else
               idle_q <= idle_q + 1'b1;
         end
         assign idle_expire = (st_q == ST_IDLE) && (idle_q == IW'(IDLE_CYC - 1));
      end else begin : g_no_idle
         assign idle_expire = 1'b0;
      end
   endgenerate

   assign req_ready = (st_q == ST_IDLE) || (st_q == ST_STBY);
   assign accept    = req_ready && req_valid;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_PWRUP: if (pu_done) st_d = ST_STBY;
         ST_STBY:  if (accept) st_d = ST_WAKE;
         ST_IDLE: begin
            if (accept)
               st_d = !req_write ? ST_RD : (last_rd_q ? ST_TURN : ST_WR);
            else if (idle_expire)
               st_d = ST_STBY;
         end
         ST_WAKE:  if (tmr_zero) st_d = wr_q ? ST_WR : ST_RD;
         ST_RD:    if (tmr_zero) st_d = ST_IDLE;
         ST_TURN:  if (tmr_zero) st_d = ST_WR;
         ST_WR:    if (tmr_zero) st_d = ST_WHOLD;
         ST_WHOLD: st_d = ST_IDLE;
         default:  st_d = ST_PWRUP;
      endcase
   end

   assign tmr_load = (st_d != st_q);
   always_comb begin
      unique case (st_d)
         ST_WAKE: tmr_val = CW'(WAKE_CYC - 1);
         ST_RD:   tmr_val = CW'(RD_CYC - 1);
         ST_TURN: tmr_val = CW'(HZ_CYC - 1);
         ST_WR:   tmr_val = CW'(PWE_CYC - 1);
         default: tmr_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_PWRUP;
         wr_q      <= 1'b0;
         last_rd_q <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         rdata_q   <= '0;
         rsp_q     <= 1'b0;
      end else begin
         st_q  <= st_d;
         rsp_q <= (st_q == ST_RD) && tmr_zero;
         if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if ((st_q == ST_RD) && tmr_zero)
            rdata_q <= sram_dq_in;
         if ((st_q == ST_RD) && (st_d != ST_RD))
            last_rd_q <= 1'b1;
         else if (st_d == ST_WR || st_d == ST_STBY)
            last_rd_q <= 1'b0;
      end
   end

   assign sram_ce_n   = (st_q == ST_PWRUP) || (st_q == ST_STBY);
   assign sram_oe_n   = (st_q != ST_RD);
   assign sram_we_n   = (st_q != ST_WR);
   assign sram_dq_oe  = (st_q == ST_WR) || (st_q == ST_WHOLD);
   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;
   assign rsp_valid   = rsp_q;
   assign rsp_rdata   = rdata_q;

   // R5
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n);
   // R5
   we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> !sram_ce_n);
   // R3
   we_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_dq_oe);
   // R3
   we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out));
   // R4
   turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> sram_oe_n && $past(sram_oe_n));
   // R2
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R1
   pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pu_done |-> sram_ce_n && !req_ready);
   // R7
   wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_ce_n) |-> sram_oe_n && sram_we_n);
   // R8
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> sram_oe_n && sram_we_n);
endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
   localparam int CLK_NS  = 10;
   localparam int RD_C    = 1;       // max(10,10,5)ns at 10ns
   localparam int HZ_C    = 1;       // 5ns
   localparam int WAKE_C  = 1;
   localparam int PU_C    = 10000;   // 100us
   localparam int IDLE_C  = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rsp_valid, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [7:0] rsp_rdata, sram_dq_out, sram_dq_in;
   logic [16:0] sram_addr;

   always #5 clk = ~clk;

   sram_async_ctrl #(.CLK_NS(CLK_NS), .IDLE_CYC(IDLE_C)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
      .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

   // ---------------- memory model ----------------
   logic [7:0] mem [256];
   assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : 8'h00;

   logic [24:0] wq [$];
   logic [7:0]  rq [$];
   int m_chk = 0, m_err = 0, s_chk = 0, s_err = 0, n_rsp = 0, ce_rises = 0, ce_falls = 0;
   logic p_we = 1, p_ce = 1, p_oe = 1, p_dqoe = 0, wake_pend = 0;
   logic [16:0] p_addr = '0;
   logic [7:0]  p_dq = '0;
   int quiet = 100, oe_lo = 0, sel_cnt = 0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!sram_we_n && (!sram_oe_n || sram_ce_n)) begin
            m_err++; $display("FAIL R5 illegal strobes ce=%b oe=%b we=%b expected we low only with ce low oe high",
                              sram_ce_n, sram_oe_n, sram_we_n);
         end
         if ((!sram_oe_n || !sram_we_n) && req_ready) begin
            m_err++; $display("FAIL R8 req_ready=1 expected 0 during strobe");
         end
         if (!sram_we_n && !p_we && (sram_addr != p_addr || sram_dq_out != p_dq)) begin
            m_err++; $display("FAIL R3 moved in pulse addr=%h dq=%h expected %h %h", sram_addr, sram_dq_out, p_addr, p_dq);
         end
         if (!p_we && sram_we_n) begin
            m_chk++;
            if (sram_addr != p_addr || sram_dq_out != p_dq || !sram_dq_oe) begin
               m_err++; $display("FAIL R3 hold addr=%h dq=%h oe=%b expected %h %h 1", sram_addr, sram_dq_out, sram_dq_oe, p_addr, p_dq);
            end
            mem[p_addr[7:0]] = p_dq;
            m_chk++;
            if (wq.size() == 0) begin
               m_err++; $display("FAIL R8 write %h=%h expected none", p_addr, p_dq);
            end else begin
               logic [24:0] e;
               e = wq.pop_front();
               if (e != {p_addr, p_dq}) begin
                  m_err++; $display("FAIL R3 commit %h expected %h", {p_addr, p_dq}, e);
               end
            end
         end
         if (sram_dq_oe && !p_dqoe) begin
            m_chk++;
            if (!sram_oe_n || quiet < HZ_C) begin
               m_err++; $display("FAIL R4 gap=%0d expected >=%0d", quiet, HZ_C);
            end
         end
         if (sram_oe_n && !p_oe) begin
            m_chk++;
            if (oe_lo < RD_C) begin
               m_err++; $display("FAIL R2 oe low %0d expected >=%0d", oe_lo, RD_C);
            end
         end
         if (sram_ce_n && !p_ce) ce_rises++;
         if (!sram_ce_n && p_ce) begin
            ce_falls++; sel_cnt = 0; wake_pend = 1;
         end
         if (wake_pend && (!sram_oe_n || !sram_we_n)) begin
            m_chk++; wake_pend = 0;
            if (sel_cnt < WAKE_C) begin
               m_err++; $display("FAIL R7 wake %0d expected >=%0d", sel_cnt, WAKE_C);
            end
         end
         if (!sram_ce_n && sram_oe_n && sram_we_n) sel_cnt++;
         if (!sram_oe_n) oe_lo++; else oe_lo = 0;
         if (!sram_oe_n) quiet = 0; else if (!sram_dq_oe) quiet++;
      end
      p_we = sram_we_n; p_ce = sram_ce_n; p_oe = sram_oe_n; p_dqoe = sram_dq_oe;
      p_addr = sram_addr; p_dq = sram_dq_out;
   end

   // ---------------- response monitor (scoreboard) ----------------
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_rsp++; s_chk++;
         if (rq.size() == 0) begin
            s_err++; $display("FAIL R2 response %h expected none", rsp_rdata);
         end else begin
            logic [7:0] e;
            e = rq.pop_front();
            if (rsp_rdata != e) begin
               s_err++; $display("FAIL R2 read data %h expected %h", rsp_rdata, e);
            end
         end
      end
   end

   // ---------------- driver ----------------
   int checks = 0, errors = 0, n_reads = 0;
   logic [7:0] shadow [256];

   task automatic chk(input bit ok, input string rq_tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++; $display("FAIL %s actual=%0d expected=%0d", rq_tag, act, exp);
      end
   endtask

   task automatic do_req(input bit lead, input logic w, input logic [16:0] a, input logic [7:0] d);
      if (lead) @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      if (w) begin
         wq.push_back({a, d}); shadow[a[7:0]] = d;
      end else begin
         rq.push_back(shadow[a[7:0]]); n_reads++;
      end
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks + m_chk + s_chk, errors + m_err + s_err);
      $finish;
   endtask

   initial begin
      repeat (PU_C + 20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      int lat, r0, f0;
      for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !req_ready, "R1 reset strobes",
          {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready}, 5'b11100);
      lat = 1;
      while (!req_ready && lat < PU_C + 10) begin
         @(negedge clk); lat++;
         if (!sram_ce_n) begin errors++; $display("FAIL R1 ce low during hold actual=0 expected=1"); end
      end
      chk(lat >= PU_C && lat <= PU_C + 3, "R1 ready latency", lat, PU_C);

      // writes from standby (wake), then back-to-back patterns
      do_req(1, 1, 17'h00000, 8'h11);
      do_req(1, 1, 17'h1FFFF, 8'hEE);
      do_req(1, 1, 17'h0A5C3, 8'h00);
      do_req(1, 1, 17'h15A3C, 8'hFF);
      do_req(1, 0, 17'h00000, 8'h00);
      do_req(1, 0, 17'h1FFFF, 8'h00);
      do_req(1, 1, 17'h00010, 8'h3C);   // write right after read: turnaround (R4)
      do_req(1, 0, 17'h00010, 8'h00);
      do_req(1, 0, 17'h0A5C3, 8'h00);
      do_req(1, 0, 17'h15A3C, 8'h00);
      do_req(1, 0, 17'h00077, 8'h00);   // untouched location
      for (int k = 0; k < 8; k++) begin
         do_req(0, k[0], {9'h0, 8'(8'h80 + k)}, 8'(k * 37));
      end
      for (int k = 0; k < 8; k++) begin
         do_req(0, 0, {9'h0, 8'(8'h80 + k)}, 8'h00);
      end
      repeat (4) @(negedge clk);

      // R6 standby after idle timeout
      repeat (IDLE_C + 2) @(negedge clk);
      chk(sram_ce_n && !sram_dq_oe, "R6 standby entered", {sram_ce_n, sram_dq_oe}, 2'b10);
      chk(req_ready, "R6 ready in standby", req_ready, 1);

      // R9 request in the last idle cycle wins
      do_req(1, 0, 17'h00081, 8'h00);
      while (!rsp_valid) @(negedge clk);
      r0 = ce_rises;
      repeat (IDLE_C - 1) @(negedge clk);
      do_req(0, 0, 17'h00082, 8'h00);
      while (!rsp_valid) @(negedge clk);
      chk(ce_rises == r0, "R9 no standby when request meets timeout", ce_rises - r0, 0);

      // one cycle later: standby first, then a wake-up (R6, R7)
      r0 = ce_rises; f0 = ce_falls;
      repeat (IDLE_C) @(negedge clk);
      chk(sram_ce_n, "R6 standby one cycle later", sram_ce_n, 1);
      do_req(0, 0, 17'h00083, 8'h00);
      while (!rsp_valid) @(negedge clk);
      chk(ce_rises == r0 + 1 && ce_falls == f0 + 1, "R7 one release and one wake", ce_rises - r0, 1);

      repeat (5) @(negedge clk);
      chk(n_rsp == n_reads, "R2 one response per read", n_rsp, n_reads);
      chk(wq.size() == 0, "R8 all writes committed", wq.size(), 0);
      chk(rq.size() == 0, "R8 all reads answered", rq.size(), 0);
      chk(m_err == 0, "R5 strobe encoding and model rules", m_err, 0);
      finish_run();
   end
endmodule